// File: doc/BRIEF.md
# Register Select and Encode Unit

This combinational unit sits between the instruction register and the register file of a multi-bus datapath. It pulls three 4-bit register specifiers out of the current instruction word and turns them into per-bus one-hot enables. Three read buses (A, B and C) and one writeback lane each choose on their own which specifier addresses them. The control sequencer drives a 3-bit field-select vector for each lane. A read strobe gates all read enables, and a write strobe gates the field-driven write enables.

A base-address mode lets address arithmetic use the constant alone. While the mode is on, a bus that addresses R0 gets no register enable. Instead the unit raises a flag that tells the bus multiplexer to drive zero. A link strobe forces the write enable of the return-address register R12, whatever the instruction fields hold. The unit also presents the instruction's 19-bit constant sign-extended to 32 bits.

Top module: `regsel_unit`

## Requirements
- R1: The specifiers are taken from fixed instruction bits: Ra = ir_word[26:23], Rb = ir_word[22:19], Rc = ir_word[18:15]. The lane that selects a specifier, with its strobe on, presents a 16-bit vector with only bit n set, where n is that specifier's value.
- R2: Bus A, Bus B, Bus C and the writeback lane each have a 3-bit select vector of their own. The result of one lane depends only on its own vector and does not depend on the vectors of the other lanes.
- R3: Select vector encoding: bit 2 picks Ra, bit 1 picks Rb and bit 0 picks Rc. When more than one bit is set, Ra wins over Rb and Rb wins over Rc.
- R4: A lane whose select vector is 3'b000 produces an all-zero enable vector.
- R5: When reg_rd_en is 0, all three read enable vectors are zero. When reg_wr_en is 0, no write enable comes from the fields.
- R6: With base_zero_en at 1, a read bus whose selected specifier is 0 has bit 0 of its enable cleared, and zero_r0 is 1. zero_r0 is 1 exactly when base_zero_en and reg_rd_en are both 1 and at least one read bus selects register 0. Read buses that select a nonzero register are unaffected.
- R7: When link_wr is 1, wr_en bit 12 is 1 whatever the fields, the select vector and reg_wr_en hold. Any field-driven write bit is still present.
- R8: const_ext equals ir_word[18:0] sign-extended from bit 18 to 32 bits. It does not depend on any strobe.
- R9: Each read enable vector has at most one bit set. wr_en has at most two bits set, and two only when link_wr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_word | input | 32 | Current instruction word |
| sel_bus_a | input | 3 | Field select for Bus A {Ra,Rb,Rc} |
| sel_bus_b | input | 3 | Field select for Bus B {Ra,Rb,Rc} |
| sel_bus_c | input | 3 | Field select for Bus C {Ra,Rb,Rc} |
| sel_wr | input | 3 | Field select for the writeback lane {Ra,Rb,Rc} |
| reg_rd_en | input | 1 | Read strobe gating all bus read enables |
| reg_wr_en | input | 1 | Write strobe gating field-driven write enables |
| base_zero_en | input | 1 | Base-address mode: R0 reads as zero |
| link_wr | input | 1 | Force write of the return-address register R12 |
| rd_en_a | output | 16 | One-hot register read enable, Bus A |
| rd_en_b | output | 16 | One-hot register read enable, Bus B |
| rd_en_c | output | 16 | One-hot register read enable, Bus C |
| wr_en | output | 16 | Register write enable vector |
| zero_r0 | output | 1 | Tells the bus multiplexer to drive zero for R0 |
| const_ext | output | 32 | Sign-extended instruction constant |

## Verification
The assertions are immediate checks on a purely combinational path. They hold only when every input is a known 0 or 1, so each check is skipped while any input carries X. The bench drives every input to a defined value from time zero and changes them only on the falling clock edge. Random stimulus draws all select vectors, strobes and instruction words over their full ranges, so priority overlaps and the R0 base-mode case are reached. Directed cases force specifier 0, specifier 15, the sign bit of the constant, and link writes with the write strobe off.

// File: rtl/regsel_pkg.sv
// Package: regsel_pkg
// Shared widths, field positions and types for the register select unit.
// Assumes a 32-bit instruction with three 4-bit specifiers and a 19-bit constant.
package regsel_pkg;
    localparam int NREG      = 16;
    localparam int IDX_W     = $clog2(NREG);
    localparam int IR_W      = 32;
    localparam int CONST_W   = 19;
    localparam int RA_LSB    = 23;
    localparam int RB_LSB    = 19;
    localparam int RC_LSB    = 15;
    localparam int LINK_REG  = 12;
    localparam int NLANE     = 4;
    localparam int NRD       = 3;

    typedef logic [IDX_W-1:0] reg_idx_t;
    typedef logic [NREG-1:0]  reg_vec_t;

    // Which specifier a lane ended up using after priority resolution
    typedef enum logic [1:0] {
        FLD_NONE = 2'd0,
        FLD_RA   = 2'd1,
        FLD_RB   = 2'd2,
        FLD_RC   = 2'd3
    } fld_pick_t;

    // The three specifiers of one instruction
    typedef struct packed {
        reg_idx_t ra;
        reg_idx_t rb;
        reg_idx_t rc;
    } spec_set_t;
endpackage

// File: rtl/regsel_field_pick.sv
// Module: regsel_field_pick
// Resolves one lane's 3-bit select vector into a single register index.
// Assumes sel bit 2 = Ra, bit 1 = Rb, bit 0 = Rc; Ra has the highest priority.
// Outputs valid=0 when no select bit is set.
module regsel_field_pick
    import regsel_pkg::*;
(
    input  logic [2:0] sel,
    input  spec_set_t  specs,
    output logic       valid,
    output reg_idx_t   idx,
    output fld_pick_t  pick
);
    // Priority choice of the specifier named by the select vector
    always_comb begin
        pick = FLD_NONE;
        idx  = '0;
        if (sel[2]) begin
            pick = FLD_RA;
            idx  = specs.ra;
        end else if (sel[1]) begin
            pick = FLD_RB;
            idx  = specs.rb;
        end else if (sel[0]) begin
            pick = FLD_RC;
            idx  = specs.rc;
        end
    end

    // A lane is active whenever any field was picked
    always_comb valid = (pick != FLD_NONE);
endmodule

// File: rtl/regsel_onehot_dec.sv
// Module: regsel_onehot_dec
// Parameterised N-way one-hot decoder with an enable.
// Assumes idx < N; an out-of-range index yields an all-zero vector.
module regsel_onehot_dec #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    // One comparator per output bit
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb onehot[g] = en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/regsel_const_ext.sv
// Module: regsel_const_ext
// Sign-extends the low constant field of the instruction to the full width.
// Assumes the constant starts at bit 0 and its sign bit is bit IN_W-1.
module regsel_const_ext #(
    parameter int IN_W  = 19,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  raw,
    output logic [OUT_W-1:0] ext
);
    localparam int PAD_W = OUT_W - IN_W;

    // Replicate the sign bit into the upper bits
    always_comb ext = {{PAD_W{raw[IN_W-1]}}, raw};
endmodule

// File: rtl/regsel_unit.sv
// Module: regsel_unit (top)
// Decodes the instruction register specifiers into per-bus one-hot read
// enables and a write enable vector, applies base-address zeroing of R0,
// forces the link register write, and sign-extends the constant.
// Assumes purely combinational use: the sequencer holds the strobes stable
// for the cycle in which the register file samples the enables.
module regsel_unit
    import regsel_pkg::*;
(
    input  logic [31:0] ir_word,
    input  logic [2:0]  sel_bus_a,
    input  logic [2:0]  sel_bus_b,
    input  logic [2:0]  sel_bus_c,
    input  logic [2:0]  sel_wr,
    input  logic        reg_rd_en,
    input  logic        reg_wr_en,
    input  logic        base_zero_en,
    input  logic        link_wr,
    output logic [15:0] rd_en_a,
    output logic [15:0] rd_en_b,
    output logic [15:0] rd_en_c,
    output logic [15:0] wr_en,
    output logic        zero_r0,
    output logic [31:0] const_ext
);
    spec_set_t  specs;
    logic [2:0] lane_sel   [NLANE];
    logic       lane_valid [NLANE];
    reg_idx_t   lane_idx   [NLANE];
    fld_pick_t  lane_pick  [NLANE];
    logic       lane_gate  [NLANE];
    reg_vec_t   lane_dec   [NLANE];
    reg_vec_t   rd_masked  [NRD];
    logic [NRD-1:0] rd_hits_r0;

    // Extract the three specifiers from their fixed bit positions
    always_comb begin
        specs.ra = ir_word[RA_LSB +: IDX_W];
        specs.rb = ir_word[RB_LSB +: IDX_W];
        specs.rc = ir_word[RC_LSB +: IDX_W];
    end

    // Gather lane selects; lanes 0..2 are read buses, lane 3 is writeback
    always_comb begin
        lane_sel[0] = sel_bus_a;
        lane_sel[1] = sel_bus_b;
        lane_sel[2] = sel_bus_c;
        lane_sel[3] = sel_wr;
    end

    // Per-lane strobe: read lanes use the read strobe, the last the write strobe
    for (genvar l = 0; l < NLANE; l++) begin : g_gate
        if (l < NRD) begin : g_rd
            always_comb lane_gate[l] = reg_rd_en;
        end else begin : g_wr
            always_comb lane_gate[l] = reg_wr_en;
        end
    end

    // One field picker and one decoder per lane
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        regsel_field_pick u_pick (
            .sel   (lane_sel[l]),
            .specs (specs),
            .valid (lane_valid[l]),
            .idx   (lane_idx[l]),
            .pick  (lane_pick[l])
        );

        regsel_onehot_dec #(
            .N     (NREG),
            .IDX_W (IDX_W)
        ) u_dec (
            .en     (lane_valid[l] && lane_gate[l]),
            .idx    (lane_idx[l]),
            .onehot (lane_dec[l])
        );
    end

    // Base-address mode suppresses the R0 enable on each read bus
    for (genvar b = 0; b < NRD; b++) begin : g_base
        always_comb begin
            rd_hits_r0[b] = lane_dec[b][0];
            rd_masked[b]  = lane_dec[b];
            if (base_zero_en) rd_masked[b][0] = 1'b0;
        end
    end

    // Drive the read enable ports
    always_comb begin
        rd_en_a = rd_masked[0];
        rd_en_b = rd_masked[1];
        rd_en_c = rd_masked[2];
    end

    // Zero flag for the bus multiplexer when any bus asked for R0 in base mode
    always_comb zero_r0 = base_zero_en && (|rd_hits_r0);

    // Field-driven write enable plus the forced link register bit
    always_comb begin
        wr_en = lane_dec[NLANE-1];
        if (link_wr) wr_en[LINK_REG] = 1'b1;
    end

    regsel_const_ext #(
        .IN_W  (CONST_W),
        .OUT_W (IR_W)
    ) u_cext (
        .raw (ir_word[CONST_W-1:0]),
        .ext (const_ext)
    );
endmodule

// File: rtl/regsel_unit_chk.sv
// Module: regsel_unit_chk
// Immediate-assertion checker bound to regsel_unit. Skips evaluation while
// any input is unknown, since the block is purely combinational.
module regsel_unit_chk (
    input logic [31:0] ir_word,
    input logic [2:0]  sel_bus_a,
    input logic [2:0]  sel_bus_b,
    input logic [2:0]  sel_bus_c,
    input logic [2:0]  sel_wr,
    input logic        reg_rd_en,
    input logic        reg_wr_en,
    input logic        base_zero_en,
    input logic        link_wr,
    input logic [15:0] rd_en_a,
    input logic [15:0] rd_en_b,
    input logic [15:0] rd_en_c,
    input logic [15:0] wr_en,
    input logic        zero_r0,
    input logic [31:0] const_ext
);
    logic known;

    // Inputs fully defined
    always_comb known = !$isunknown({ir_word, sel_bus_a, sel_bus_b, sel_bus_c,
                                     sel_wr, reg_rd_en, reg_wr_en,
                                     base_zero_en, link_wr});

    // Property checks on the outputs
    always_comb begin
        if (known) begin
            AST_RD_ONEHOT: assert ($onehot0(rd_en_a) && $onehot0(rd_en_b) && $onehot0(rd_en_c)); // R9
            AST_WR_COUNT: assert ($countones(wr_en) <= (link_wr ? 2 : 1)); // R9
            AST_NO_SEL_ZERO: assert (sel_bus_a != 3'b000 || rd_en_a == 16'h0); // R4
            AST_RD_GATE: assert (reg_rd_en || (rd_en_a | rd_en_b | rd_en_c) == 16'h0); // R5
            AST_WR_GATE: assert (reg_wr_en || link_wr || wr_en == 16'h0); // R5
            AST_LINK_BIT: assert (!link_wr || wr_en[12]); // R7
            AST_BASE_R0: assert (!base_zero_en || (rd_en_a[0] | rd_en_b[0] | rd_en_c[0]) == 1'b0); // R6
            AST_ZERO_NEEDS_BASE: assert (!zero_r0 || (base_zero_en && reg_rd_en)); // R6
            AST_CONST_SIGN: assert (const_ext[31:19] == {13{ir_word[18]}} && const_ext[18:0] == ir_word[18:0]); // R8
        end
    end
endmodule

bind regsel_unit regsel_unit_chk u_chk (
    .ir_word      (ir_word),
    .sel_bus_a    (sel_bus_a),
    .sel_bus_b    (sel_bus_b),
    .sel_bus_c    (sel_bus_c),
    .sel_wr       (sel_wr),
    .reg_rd_en    (reg_rd_en),
    .reg_wr_en    (reg_wr_en),
    .base_zero_en (base_zero_en),
    .link_wr      (link_wr),
    .rd_en_a      (rd_en_a),
    .rd_en_b      (rd_en_b),
    .rd_en_c      (rd_en_c),
    .wr_en        (wr_en),
    .zero_r0      (zero_r0),
    .const_ext    (const_ext)
);

// File: tb/regsel_unit_bench.sv
`timescale 1ns/1ps
// Bench for regsel_unit: directed corners plus seeded random stimulus,
// compared against reference functions written from the requirements.
module regsel_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ir_word = '0;
    logic [2:0]  sel_bus_a = '0, sel_bus_b = '0, sel_bus_c = '0, sel_wr = '0;
    logic        reg_rd_en = 1'b0, reg_wr_en = 1'b0, base_zero_en = 1'b0, link_wr = 1'b0;
    logic [15:0] rd_en_a, rd_en_b, rd_en_c, wr_en;
    logic        zero_r0;
    logic [31:0] const_ext;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    regsel_unit u_regsel_unit (
        .ir_word(ir_word), .sel_bus_a(sel_bus_a), .sel_bus_b(sel_bus_b),
        .sel_bus_c(sel_bus_c), .sel_wr(sel_wr), .reg_rd_en(reg_rd_en),
        .reg_wr_en(reg_wr_en), .base_zero_en(base_zero_en), .link_wr(link_wr),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_en_c(rd_en_c),
        .wr_en(wr_en), .zero_r0(zero_r0), .const_ext(const_ext)
    );

    // Index chosen by a select vector, -1 when none (R1, R3)
    function automatic int pick_idx(input logic [31:0] ir, input logic [2:0] s);
        if (s[2]) return int'(ir[26:23]);
        if (s[1]) return int'(ir[22:19]);
        if (s[0]) return int'(ir[18:15]);
        return -1;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [31:0] ir, input logic [2:0] s,
                                           input logic rd, input logic base);
        int i = pick_idx(ir, s);
        logic [15:0] v = '0;
        if (rd && i >= 0) v[i] = 1'b1;
        if (base) v[0] = 1'b0;
        return v;
    endfunction

    function automatic logic hits_r0(input logic [31:0] ir, input logic [2:0] s, input logic rd);
        return rd && (pick_idx(ir, s) == 0);
    endfunction

    function automatic logic [15:0] exp_wr(input logic [31:0] ir, input logic [2:0] s,
                                           input logic we, input logic lk);
        int i = pick_idx(ir, s);
        logic [15:0] v = '0;
        if (we && i >= 0) v[i] = 1'b1;
        if (lk) v[12] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one input set on the falling edge and compare all outputs
    task automatic apply(input logic [31:0] ir, input logic [2:0] a, input logic [2:0] b,
                         input logic [2:0] c, input logic [2:0] w, input logic rd,
                         input logic we, input logic base, input logic lk);
        logic zf;
        @(negedge clk);
        ir_word = ir; sel_bus_a = a; sel_bus_b = b; sel_bus_c = c; sel_wr = w;
        reg_rd_en = rd; reg_wr_en = we; base_zero_en = base; link_wr = lk;
        #2;
        zf = base && (hits_r0(ir, a, rd) || hits_r0(ir, b, rd) || hits_r0(ir, c, rd));
        chk("R1/R3 bus A", {16'h0, rd_en_a}, {16'h0, exp_rd(ir, a, rd, base)});
        chk("R2/R5 bus B", {16'h0, rd_en_b}, {16'h0, exp_rd(ir, b, rd, base)});
        chk("R2/R4 bus C", {16'h0, rd_en_c}, {16'h0, exp_rd(ir, c, rd, base)});
        chk("R7/R5 write", {16'h0, wr_en},   {16'h0, exp_wr(ir, w, we, lk)});
        chk("R6 zero flag", {31'h0, zero_r0}, {31'h0, zf});
        chk("R8 constant", const_ext, {{13{ir[18]}}, ir[18:0]});
    endtask

    // Build an instruction from specifiers and constant low bits
    function automatic logic [31:0] mk(input logic [3:0] ra, input logic [3:0] rb,
                                       input logic [3:0] rc, input logic [14:0] lo,
                                       input logic [4:0] op);
        return {op, ra, rb, rc, lo};
    endfunction

    initial begin
        void'($urandom(32'h5eed_0374));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // reset state: all strobes low -> all enables zero (R4, R5)
        #2;
        chk("R4 idle rd A", {16'h0, rd_en_a}, 32'h0);
        chk("R5 idle wr", {16'h0, wr_en}, 32'h0);
        chk("R6 idle zero", {31'h0, zero_r0}, 32'h0);
        // R1 each field alone, extremes 0 and 15
        apply(mk(4'd15, 4'd3, 4'd9, 15'h0, 5'd0), 3'b100, 3'b010, 3'b001, 3'b100, 1, 1, 0, 0);
        apply(mk(4'd0, 4'd15, 4'd0, 15'h1, 5'd1), 3'b100, 3'b010, 3'b001, 3'b010, 1, 1, 0, 0);
        // R3 overlaps: 111 -> Ra, 011 -> Rb
        apply(mk(4'd5, 4'd6, 4'd7, 15'h0, 5'd2), 3'b111, 3'b011, 3'b101, 3'b011, 1, 1, 0, 0);
        // R4 no select on all lanes
        apply(mk(4'd5, 4'd6, 4'd7, 15'h0, 5'd2), 3'b000, 3'b000, 3'b000, 3'b000, 1, 1, 0, 0);
        // R5 strobes off
        apply(mk(4'd4, 4'd8, 4'd2, 15'h0, 5'd3), 3'b100, 3'b010, 3'b001, 3'b001, 0, 0, 0, 0);
        // R6 base mode with R0 on bus B, nonzero on A
        apply(mk(4'd3, 4'd0, 4'd11, 15'h0, 5'd16), 3'b100, 3'b010, 3'b001, 3'b100, 1, 1, 1, 0);
        // R6 base mode, no bus at R0 -> flag low
        apply(mk(4'd3, 4'd1, 4'd11, 15'h0, 5'd16), 3'b100, 3'b010, 3'b001, 3'b000, 1, 0, 1, 0);
        // R6 R0 selected but read strobe off -> flag low
        apply(mk(4'd0, 4'd0, 4'd0, 15'h0, 5'd16), 3'b100, 3'b010, 3'b001, 3'b000, 0, 0, 1, 0);
        // R7 link with write strobe off, and with a field write to R12 and to R2
        apply(mk(4'd7, 4'd1, 4'd2, 15'h0, 5'd19), 3'b100, 3'b000, 3'b000, 3'b100, 1, 0, 0, 1);
        apply(mk(4'd12, 4'd1, 4'd2, 15'h0, 5'd19), 3'b000, 3'b000, 3'b000, 3'b100, 0, 1, 0, 1);
        apply(mk(4'd2, 4'd1, 4'd2, 15'h0, 5'd19), 3'b000, 3'b000, 3'b000, 3'b100, 0, 1, 0, 1);
        // R8 constant sign edges
        apply(32'h0004_0000, 3'b000, 3'b000, 3'b000, 3'b000, 0, 0, 0, 0);
        apply(32'h0003_FFFF, 3'b000, 3'b000, 3'b000, 3'b000, 0, 0, 0, 0);
        apply(32'hFFFF_FFFF, 3'b111, 3'b111, 3'b111, 3'b111, 1, 1, 1, 1);
        // Random sweep covering R1..R9
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r = $urandom;
            logic [31:0] s = $urandom;
            if (s[20:19] == 2'b00) r[22:19] = 4'd0;
            apply(r, s[2:0], s[5:3], s[8:6], s[11:9], s[12], s[13], s[14], s[15]);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog ending a hung run as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule